// File: doc/BRIEF.md
# Encoded-Interval Watchdog Timer

This block is a watchdog whose timeout comes from one 8-bit control byte. The low two bits pick a resolution code and the next five bits give a multiplier. Together they set a period counted in ticks of an external strobe that pulses once every sixteenth of a second. Bit 7 steers what happens when the period runs out. If the byte decodes to a period of zero, the watchdog is off.

Software keeps the watchdog alive by touching the control byte. A write loads a new value and starts a fresh count. A read starts a fresh count from the value already stored. Both also clear the expiry flag.

When the count runs out, the flag is set. With bit 7 set, the block gives a one-cycle reset request and clears the control byte to zero, which disables the watchdog. With bit 7 clear, it gives a one-cycle interrupt pulse and then sits idle until software touches the byte again. All pins are plain control and status signals. There is no data stream, so there is no valid/ready handshake.

Top module: `ivwdt`

## Requirements
- R1: The period in ticks is the multiplier (bits [6:2]) shifted left by twice the resolution code (bits [1:0]). Expiry happens on exactly that tick counted after a restart. Cycles with `tick` low do not advance the count.
- R2: A control value whose period decodes to zero never expires and produces no flag and no pulse. This covers a value of zero and also a zero multiplier with a nonzero resolution code.
- R3: A write loads `wr_data` into the control byte, restarts the count from zero and clears the flag on the next cycle.
- R4: A read restarts the count from zero using the stored byte and clears the flag. The control byte itself is always visible on `ctrl_q`.
- R5: On expiry `expired` goes to 1 in the same cycle as the pulse. It stays at 1 until the next read or write.
- R6: On expiry with bit 7 set, `rst_req` is high for exactly one cycle and the control byte reads 0x00 from that cycle on.
- R7: On expiry with bit 7 clear, `irq` is high for exactly one cycle and the control byte keeps its value. `irq` and `rst_req` are never high together.
- R8: After an interrupt-style expiry, further ticks produce no flag change and no pulse until the next read or write.
- R9: When a read and a write arrive in the same cycle, the write takes effect and the count restarts with the written value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | One-cycle strobe, once per 1/16 second |
| reg_wr | input | 1 | Write strobe for the control byte |
| reg_rd | input | 1 | Read strobe for the control byte (restarts the count) |
| wr_data | input | 8 | Write data |
| ctrl_q | output | 8 | Current control byte |
| expired | output | 1 | Expiry flag |
| rst_req | output | 1 | One-cycle reset request |
| irq | output | 1 | One-cycle interrupt pulse |

## Verification
A wrong internal count moves the expiry pulse off its tick. Because the bench checks after every tick that no pulse has come yet and then requires the pulse on the exact final tick, the error shows up within one tick of where it goes wrong. A stale armed state shows up in three ways: a disabled value that still fires, a second interrupt after the first, or a restart that fails to push expiry back. Each of these is seen at `irq`, `rst_req` or `expired` within the period under test. A wrong steering decision shows up on the very cycle of expiry, either as the wrong pulse or as `ctrl_q` not reading zero.

// File: rtl/ivwdt_pkg.sv
package ivwdt_pkg;
  localparam int unsigned RES_W    = 2;
  localparam int unsigned MULT_W   = 5;
  localparam int unsigned CTRL_W   = RES_W + MULT_W + 1;
  localparam int unsigned STEER_IX = CTRL_W - 1;
  localparam int unsigned MAX_SH   = 2 * ((1 << RES_W) - 1);
  localparam int unsigned CNT_W    = MULT_W + MAX_SH;
endpackage

// File: rtl/ivwdt_decode.sv
module ivwdt_decode #(
  parameter int unsigned RES_W  = 2,
  parameter int unsigned MULT_W = 5,
  localparam int unsigned CTRL_W = RES_W + MULT_W + 1,
  localparam int unsigned NCODE  = 1 << RES_W,
  localparam int unsigned CNT_W  = MULT_W + 2 * (NCODE - 1)
) (
  input  logic [CTRL_W-1:0] ctrl,
  output logic [CNT_W-1:0]  period
);
  logic [MULT_W-1:0] mult;
  logic [RES_W-1:0]  res;
  logic [CNT_W-1:0]  scaled [NCODE];

  assign mult = ctrl[RES_W +: MULT_W];
  assign res  = ctrl[RES_W-1:0];

  for (genvar g = 0; g < NCODE; g++) begin : g_scale
    assign scaled[g] = CNT_W'(mult) << (2 * g);
  end

  assign period = scaled[res];
endmodule

// File: rtl/ivwdt_counter.sv
module ivwdt_counter #(
  parameter int unsigned CNT_W = 11
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             restart,
  input  logic             tick,
  input  logic [CNT_W-1:0] period,
  output logic             armed,
  output logic             fire
);
  logic [CNT_W-1:0] cnt;
  logic             last;

  assign last = (cnt == period - CNT_W'(1));
  assign fire = armed && tick && !restart && last;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      armed <= 1'b0;
      cnt   <= '0;
    end else if (restart) begin
      armed <= (period != '0);
      cnt   <= '0;
    end else if (fire) begin
      armed <= 1'b0;
      cnt   <= '0;
    end else if (armed && tick) begin
      cnt <= cnt + CNT_W'(1);
    end
  end

  // R2: an armed counter never runs on a zero period
  p_armed_nonzero_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && !restart) |-> (period != '0));
  // R1: the count stays below the period while armed
  p_cnt_below_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && !restart) |-> (cnt < period));
  // R8: after firing the counter is idle until a restart
  p_idle_after_fire_r8: assert property (@(posedge clk) disable iff (!rst_n)
    fire |=> !armed);
endmodule

// File: rtl/ivwdt.sv
module ivwdt
  import ivwdt_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [CTRL_W-1:0] wr_data,
  output logic [CTRL_W-1:0] ctrl_q,
  output logic              expired,
  output logic              rst_req,
  output logic              irq
);
  logic [CTRL_W-1:0] ctrl_r;
  logic [CTRL_W-1:0] dec_src;
  logic [CNT_W-1:0]  period;
  logic              restart;
  logic              armed;
  logic              fire;
  logic              steer;

  assign restart = reg_wr || reg_rd;
  assign dec_src = reg_wr ? wr_data : ctrl_r;
  assign steer   = ctrl_r[STEER_IX];

  ivwdt_decode #(.RES_W(RES_W), .MULT_W(MULT_W)) u_decode (
    .ctrl   (dec_src),
    .period (period)
  );

  ivwdt_counter #(.CNT_W(CNT_W)) u_counter (
    .clk     (clk),
    .rst_n   (rst_n),
    .restart (restart),
    .tick    (tick),
    .period  (period),
    .armed   (armed),
    .fire    (fire)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl_r  <= '0;
      expired <= 1'b0;
      rst_req <= 1'b0;
      irq     <= 1'b0;
    end else begin
      if (reg_wr)             ctrl_r <= wr_data;
      else if (fire && steer) ctrl_r <= '0;
      if (restart)            expired <= 1'b0;
      else if (fire)          expired <= 1'b1;
      rst_req <= fire && steer;
      irq     <= fire && !steer;
    end
  end

  assign ctrl_q = ctrl_r;

  // R7: the two pulses are exclusive
  p_pulse_excl_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({rst_req, irq}));
  // R6: reset request lasts one cycle
  p_rst_width_r6: assert property (@(posedge clk) disable iff (!rst_n)
    rst_req |=> !rst_req);
  // R7: interrupt lasts one cycle
  p_irq_width_r7: assert property (@(posedge clk) disable iff (!rst_n)
    irq |=> !irq);
  // R6: a reset-style expiry leaves the control byte cleared
  p_rst_clears_r6: assert property (@(posedge clk) disable iff (!rst_n)
    rst_req |-> (ctrl_q == '0));
  // R5: any pulse comes with the flag
  p_flag_with_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (rst_req || irq) |-> expired);
  // R3: a write clears the flag
  p_wr_clears_flag_r3: assert property (@(posedge clk) disable iff (!rst_n)
    reg_wr |=> !expired);
  // R9: a write always lands, even alongside a read
  p_wr_loads_r9: assert property (@(posedge clk) disable iff (!rst_n)
    reg_wr |=> (ctrl_q == $past(wr_data)));
endmodule

// File: tb/ivwdt_bench.sv
module ivwdt_bench;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick = 1'b0;
  logic       reg_wr = 1'b0;
  logic       reg_rd = 1'b0;
  logic [7:0] wr_data = '0;
  logic [7:0] ctrl_q;
  logic       expired, rst_req, irq;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  ivwdt u_ivwdt (
    .clk(clk), .rst_n(rst_n), .tick(tick), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .wr_data(wr_data), .ctrl_q(ctrl_q), .expired(expired),
    .rst_req(rst_req), .irq(irq)
  );

  function automatic int period_of(input logic [7:0] v);
    return int'(v[6:2]) << (2 * int'(v[1:0]));
  endfunction

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic chk_out(input string tag, input bit f, input bit r, input bit i);
    chk(expired == f, {tag, " flag"}, int'(expired), int'(f));
    chk(rst_req == r, {tag, " rst_req"}, int'(rst_req), int'(r));
    chk(irq == i, {tag, " irq"}, int'(irq), int'(i));
  endtask

  task automatic do_write(input logic [7:0] v, input bit with_rd);
    reg_wr = 1'b1; reg_rd = with_rd; wr_data = v;
    @(negedge clk);
    reg_wr = 1'b0; reg_rd = 1'b0;
  endtask

  task automatic do_read();
    reg_rd = 1'b1;
    @(negedge clk);
    reg_rd = 1'b0;
  endtask

  task automatic one_tick();
    tick = 1'b1;
    @(negedge clk);
    tick = 1'b0;
  endtask

  // n ticks with random idle gaps, checking nothing fires
  task automatic quiet_ticks(input int n, input string tag, input bit flag_exp);
    for (int k = 0; k < n; k++) begin
      if (($urandom % 4) == 0) @(negedge clk);
      one_tick();
      chk_out(tag, flag_exp, 1'b0, 1'b0);
    end
  endtask

  task automatic expect_expiry(input logic [7:0] v);
    one_tick();
    chk_out("R5/R6/R7 expiry", 1'b1, v[7], !v[7]);
    chk(ctrl_q == (v[7] ? 8'h00 : v), "R6/R7 ctrl after expiry", int'(ctrl_q),
        v[7] ? 0 : int'(v));
    @(negedge clk);
    chk_out("R6/R7 pulse width", 1'b1, 1'b0, 1'b0);
  endtask

  initial begin
    #(CLK_PERIOD * 190000);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [7:0] v;
    int n;
    void'($urandom(32'h1234_5678));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk_out("reset", 1'b0, 1'b0, 1'b0);
    chk(ctrl_q == 8'h00, "reset ctrl", int'(ctrl_q), 0);

    // R2: zero and zero-multiplier values stay disabled
    do_write(8'h00, 1'b0);
    quiet_ticks(40, "R2 zero", 1'b0);
    do_write(8'h83, 1'b0);
    quiet_ticks(40, "R2 mult zero", 1'b0);

    // R1 exact boundary, R7 irq, R8 no repeat
    v = 8'h09; // mult 2, res 1 -> 8 ticks
    do_write(v, 1'b0);
    chk(ctrl_q == v, "R3 write loads", int'(ctrl_q), int'(v));
    quiet_ticks(7, "R1 before expiry", 1'b0);
    expect_expiry(v);
    quiet_ticks(30, "R8 no repeat", 1'b1);

    // R4: read clears flag and restarts with stored value
    do_read();
    chk(expired == 1'b0, "R4 read clears flag", int'(expired), 0);
    quiet_ticks(5, "R4 partial", 1'b0);
    do_read();
    quiet_ticks(7, "R4 restarted", 1'b0);
    expect_expiry(v);

    // R3: write mid-count restarts and clears flag
    do_write(8'h04, 1'b0); // 1 tick
    expect_expiry(8'h04);
    do_write(8'h0C, 1'b0); // 3 ticks
    chk(expired == 1'b0, "R3 write clears flag", int'(expired), 0);
    quiet_ticks(2, "R3 partial", 1'b0);
    do_write(8'h0C, 1'b0);
    quiet_ticks(2, "R3 restarted", 1'b0);
    expect_expiry(8'h0C);

    // R9: write wins over simultaneous read
    do_write(8'h10, 1'b0); // 4 ticks
    quiet_ticks(2, "R9 partial", 1'b0);
    v = 8'h95; // mult 5, res 1 -> 20 ticks, reset style
    do_write(v, 1'b1);
    chk(ctrl_q == v, "R9 write wins", int'(ctrl_q), int'(v));
    quiet_ticks(19, "R9 new period", 1'b0);
    expect_expiry(v);
    quiet_ticks(10, "R6 disabled after reset", 1'b1);

    // Random mix
    for (int it = 0; it < 40; it++) begin
      v = 8'($urandom);
      n = period_of(v);
      do_write(v, 1'($urandom % 2));
      if (n == 0) begin
        quiet_ticks(20, "R2 random", 1'b0);
      end else begin
        quiet_ticks(n - 1, "R1 random", 1'b0);
        expect_expiry(v);
      end
    end

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule